// File: doc/BRIEF.md
# Burst-Locked Quadrature Chroma Demodulator

This block turns a stream of separated chroma samples into two colour-difference components. The samples arrive at a fixed, free-running rate that bears no relation to line sync or to the colour subcarrier. An internal numerically controlled oscillator produces a sine and cosine pair at the nominal subcarrier frequency (3.579545 MHz against a 50 MHz sample rate). Each accepted sample is multiplied by both references. Each product is passed through a power-of-two moving average, and the two averages leave as the signed `i_out` and `q_out` values.

The oscillator does not run freely. While `burst_gate` is high, the product of the chroma sample and the sine reference is summed as a phase error. When the gate falls, the sum drives a proportional-plus-integral correction of the tuning word. The correction is clamped to a programmable deviation from nominal, and the sum is then cleared. A lock flag reports whether a programmable number of consecutive bursts stayed inside an error threshold.

Both streams use valid/ready. The output is a single register stage. A new sample is accepted when `in_valid` is high and `in_ready` is high, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds and no input is taken. The loop update on a gate fall does not wait for the stream, so it can happen during a stall.

Top module: `chroma_qdemod`

## Requirements
- R1: After a synchronous reset, `out_valid` and `locked` are 0, and `tune_word` equals the nominal word round(3.579545e6 / 50e6 * 2^32). Reset also clears the error sum, the integrator, the lock counter, the oscillator phase and the filter history.
- R2: `in_ready` = !out_valid || out_ready. A sample is taken on a clock edge where in_valid and in_ready are both 1. While out_valid=1 and out_ready=0, `out_valid`, `i_out` and `q_out` hold their values.
- R3: The 32-bit oscillator phase starts at 0 and grows by `tune_word` on every accepted sample. The phase used for a sample is the phase before its own increment. With a = phase[31:22], sine = round(2047*sin(2*pi*(a+0.5)/1024)), rounding half away from zero. Cosine uses the same formula at address (a+256) mod 1024.
- R4: For each accepted sample x, the I product is x*cosine and the Q product is x*sine. `i_out` and `q_out` are the sums of the last 8 products of each channel, shifted right arithmetically by 3. `out_valid` first rises on the edge that takes the 8th sample after reset.
- R5: The phase error is the sum of the Q products of the samples accepted while `burst_gate` is 1.
- R6: A gate fall is an edge where `burst_gate` was 1 at the previous edge and is 0 now. The loop update happens only on a gate fall, whether or not a sample is taken. At every other edge `tune_word` stays unchanged. The error sum is cleared on the fall.
- R7: On a fall with error e: integ' = clamp(integ - (e>>>12), L), then offset = clamp(integ' - (e>>>8), L), and tune_word = nominal + offset. Here clamp limits to [-L, L] and L = `loop_lim`.
- R8: On a fall, a burst counts as good when |e| < `lock_thr`. A good burst adds one to a saturating counter, and `locked` is set when the counter reaches `lock_need`. A bad burst clears the counter and `locked`. `locked` changes only on a fall.
- R9: Right after every loop update, |tune_word - nominal| <= `loop_lim`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Chroma sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 10 | Signed chroma sample |
| burst_gate | input | 1 | High during the colour burst |
| out_ready | input | 1 | Downstream accepts I/Q |
| out_valid | output | 1 | I/Q pair valid |
| i_out | output | 22 | Signed in-phase average |
| q_out | output | 22 | Signed quadrature average |
| loop_lim | input | 24 | Largest allowed tuning offset from nominal |
| lock_thr | input | 40 | Error magnitude bound for a good burst |
| lock_need | input | 8 | Consecutive good bursts needed for lock |
| tune_word | output | 32 | Present oscillator tuning word |
| locked | output | 1 | Burst lock indication |

## Verification
Two things can land on the same edge: the loop update on a `burst_gate` fall and a stream stall, where out_valid is high, out_ready is low and the held I/Q pair must stay untouched. The bench provokes this by holding `out_ready` low for the cycles around several gate falls. It then expects `tune_word` to move to its new value on the fall edge while `i_out`, `q_out` and the oscillator phase stay frozen. The same stimulus also places an accepted sample on a fall edge, where the phase must advance with the old word. A cycle-exact arithmetic model in the bench judges both cases.

// File: rtl/cqd_pkg.sv
package cqd_pkg;
  localparam int LW = 48;

  function automatic logic signed [LW-1:0] clamp_sym(input logic signed [LW-1:0] v,
                                                     input logic signed [LW-1:0] lim);
    if (v > lim)
      return lim;
    else if (v < -lim)
      return -lim;
    else
      return v;
  endfunction
endpackage

// File: rtl/cqd_nco.sv
module cqd_nco #(
  parameter int PH_W   = 32,
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  input  logic [PH_W-1:0]         tune,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  localparam int QW  = ADDR_W - 2;
  localparam int QN  = 1 << QW;
  localparam int AMP = (1 << (AMP_W - 1)) - 1;

  logic [PH_W-1:0]         phase;
  logic signed [AMP_W-1:0] qtab [QN];
  logic [ADDR_W-1:0]       addr_s, addr_c;

  for (genvar k = 0; k < QN; k++) begin : g_qtab
    localparam real ANG = 2.0 * 3.141592653589793 * (real'(k) + 0.5) / real'(1 << ADDR_W);
    assign qtab[k] = AMP_W'($rtoi($floor(real'(AMP) * $sin(ANG) + 0.5)));
  end

  function automatic logic signed [AMP_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [QW-1:0] idx;
    idx = a[ADDR_W-2] ? ~a[QW-1:0] : a[QW-1:0];
    return a[ADDR_W-1] ? -qtab[idx] : qtab[idx];
  endfunction

  assign addr_s = phase[PH_W-1 -: ADDR_W];
  assign addr_c = addr_s + ADDR_W'(QN);
  assign sin_o  = fold(addr_s);
  assign cos_o  = fold(addr_c);

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (step)
      phase <= phase + tune;
  end
endmodule

// File: rtl/cqd_mavg.sv
module cqd_mavg #(
  parameter int IN_W  = 22,
  parameter int LOG_N = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  input  logic signed [IN_W-1:0] din,
  output logic signed [IN_W-1:0] avg
);
  localparam int N     = 1 << LOG_N;
  localparam int SUM_W = IN_W + LOG_N;

  logic signed [IN_W-1:0]  tap [N];
  logic signed [SUM_W-1:0] sum, sum_n;

  for (genvar k = 0; k < N; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)
          tap[k] <= '0;
        else if (step)
          tap[k] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)
          tap[k] <= '0;
        else if (step)
          tap[k] <= tap[k-1];
      end
    end
  end

  assign sum_n = sum + SUM_W'(din) - SUM_W'(tap[N-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum <= '0;
      avg <= '0;
    end else if (step) begin
      sum <= sum_n;
      avg <= IN_W'(sum_n >>> LOG_N);
    end
  end
endmodule

// File: rtl/cqd_loop.sv
module cqd_loop
  import cqd_pkg::*;
#(
  parameter int              PROD_W = 22,
  parameter int              ERR_W  = 40,
  parameter int              PH_W   = 32,
  parameter int              LIM_W  = 24,
  parameter int              THR_W  = 40,
  parameter int              CNT_W  = 8,
  parameter int              KP_SH  = 8,
  parameter int              KI_SH  = 12,
  parameter logic [PH_W-1:0] NOM    = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     gate,
  input  logic signed [PROD_W-1:0] q_prod,
  input  logic [LIM_W-1:0]         lim,
  input  logic [THR_W-1:0]         thr,
  input  logic [CNT_W-1:0]         need,
  output logic [PH_W-1:0]          tune,
  output logic                     lock
);
  logic                    gate_d, fall;
  logic signed [ERR_W-1:0] err;
  logic signed [LW-1:0]    integ;
  logic signed [LW-1:0]    e, limx, integ_s, off_s, mag, thrx;
  logic [CNT_W-1:0]        cnt, cnt_n;
  logic                    good;

  assign fall = gate_d && !gate;

  always_comb begin
    e       = LW'(err);
    limx    = $signed({{(LW-LIM_W){1'b0}}, lim});
    thrx    = $signed({{(LW-THR_W){1'b0}}, thr});
    integ_s = clamp_sym(integ - (e >>> KI_SH), limx);
    off_s   = clamp_sym(integ_s - (e >>> KP_SH), limx);
    mag     = (e < 0) ? -e : e;
    good    = mag < thrx;
    if (!good)
      cnt_n = '0;
    else if (cnt == {CNT_W{1'b1}})
      cnt_n = cnt;
    else
      cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d <= 1'b0;
      err    <= '0;
      integ  <= '0;
      tune   <= NOM;
      cnt    <= '0;
      lock   <= 1'b0;
    end else begin
      gate_d <= gate;
      if (fall) begin
        err   <= '0;
        integ <= integ_s;
        tune  <= PH_W'(LW'(NOM) + off_s);
        cnt   <= cnt_n;
        lock  <= good && (cnt_n >= need);
      end else if (step && gate) begin
        err <= err + ERR_W'(q_prod);
      end
    end
  end
endmodule

// File: rtl/chroma_qdemod.sv
module chroma_qdemod #(
  parameter int  DATA_W = 10,
  parameter int  AMP_W  = 12,
  parameter int  PH_W   = 32,
  parameter int  ADDR_W = 10,
  parameter int  LOG_N  = 3,
  parameter int  ERR_W  = 40,
  parameter int  LIM_W  = 24,
  parameter int  THR_W  = 40,
  parameter int  CNT_W  = 8,
  parameter int  KP_SH  = 8,
  parameter int  KI_SH  = 12,
  parameter real F_SC   = 3.579545e6,
  parameter real F_S    = 50.0e6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic signed [DATA_W-1:0]         in_data,
  input  logic                             burst_gate,
  input  logic                             out_ready,
  output logic                             out_valid,
  output logic signed [DATA_W+AMP_W-1:0]   i_out,
  output logic signed [DATA_W+AMP_W-1:0]   q_out,
  input  logic [LIM_W-1:0]                 loop_lim,
  input  logic [THR_W-1:0]                 lock_thr,
  input  logic [CNT_W-1:0]                 lock_need,
  output logic [PH_W-1:0]                  tune_word,
  output logic                             locked
);
  localparam int              PROD_W = DATA_W + AMP_W;
  localparam int              N      = 1 << LOG_N;
  localparam logic [PH_W-1:0] NOM    = PH_W'($rtoi(F_SC / F_S * (2.0 ** PH_W) + 0.5));

  logic                     step;
  logic signed [AMP_W-1:0]  ref_s, ref_c;
  logic signed [PROD_W-1:0] i_prod, q_prod;
  logic [LOG_N:0]           fill, fill_n;
  logic                     ov_q;

  assign in_ready  = !ov_q || out_ready;
  assign step      = in_valid && in_ready;
  assign out_valid = ov_q;

  assign i_prod = PROD_W'(in_data) * PROD_W'(ref_c);
  assign q_prod = PROD_W'(in_data) * PROD_W'(ref_s);
  assign fill_n = (fill == (LOG_N+1)'(N)) ? fill : fill + 1'b1;

  cqd_nco #(.PH_W(PH_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) nco_i (
    .clk(clk), .rst(rst), .step(step), .tune(tune_word),
    .sin_o(ref_s), .cos_o(ref_c)
  );

  cqd_mavg #(.IN_W(PROD_W), .LOG_N(LOG_N)) avg_i_i (
    .clk(clk), .rst(rst), .step(step), .din(i_prod), .avg(i_out)
  );

  cqd_mavg #(.IN_W(PROD_W), .LOG_N(LOG_N)) avg_q_i (
    .clk(clk), .rst(rst), .step(step), .din(q_prod), .avg(q_out)
  );

  cqd_loop #(
    .PROD_W(PROD_W), .ERR_W(ERR_W), .PH_W(PH_W), .LIM_W(LIM_W), .THR_W(THR_W),
    .CNT_W(CNT_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .NOM(NOM)
  ) loop_i (
    .clk(clk), .rst(rst), .step(step), .gate(burst_gate), .q_prod(q_prod),
    .lim(loop_lim), .thr(lock_thr), .need(lock_need),
    .tune(tune_word), .lock(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      ov_q <= 1'b0;
    end else if (step) begin
      fill <= fill_n;
      ov_q <= (fill_n == (LOG_N+1)'(N));
    end else begin
      ov_q <= ov_q && !out_ready;
    end
  end
endmodule

// File: rtl/chroma_qdemod_chk.sv
module chroma_qdemod_chk #(
  parameter int  OUT_W = 22,
  parameter int  PH_W  = 32,
  parameter int  LIM_W = 24,
  parameter real F_SC  = 3.579545e6,
  parameter real F_S   = 50.0e6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    burst_gate,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] i_out,
  input logic signed [OUT_W-1:0] q_out,
  input logic [PH_W-1:0]         tune_word,
  input logic [LIM_W-1:0]        loop_lim,
  input logic                    locked
);
  localparam logic [PH_W-1:0] NOM = PH_W'($rtoi(F_SC / F_S * (2.0 ** PH_W) + 0.5));

  logic              g1, fall_c, fall_q;
  logic signed [PH_W:0] dev, mag;

  assign fall_c = g1 && !burst_gate;
  assign dev    = $signed({1'b0, tune_word}) - $signed({1'b0, NOM});
  assign mag    = (dev < 0) ? -dev : dev;

  always_ff @(posedge clk) begin
    if (rst) begin
      g1     <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      g1     <= burst_gate;
      fall_q <= fall_c;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !locked && tune_word == NOM));

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(i_out) && $stable(q_out)));

  a_r6_tune_only_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall_c |=> $stable(tune_word));

  a_r8_lock_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(locked) && !$past(rst)) |-> fall_q);

  a_r9_offset_bounded: assert property (@(posedge clk) disable iff (rst)
    fall_c |=> (mag <= $signed({{(PH_W+1-LIM_W){1'b0}}, $past(loop_lim)})));
endmodule

bind chroma_qdemod chroma_qdemod_chk chk_i (
  .clk(clk), .rst(rst), .burst_gate(burst_gate), .out_valid(out_valid),
  .out_ready(out_ready), .i_out(i_out), .q_out(q_out), .tune_word(tune_word),
  .loop_lim(loop_lim), .locked(locked)
);

// File: tb/chroma_qdemod_tb_top.sv
module chroma_qdemod_tb_top;
  localparam real FSC = 3.579545e6;
  localparam real FS  = 50.0e6;
  localparam real PI  = 3.141592653589793;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [9:0]  in_data = '0;
  logic               burst_gate = 1'b0;
  logic               out_ready = 1'b1;
  logic               out_valid;
  logic signed [21:0] i_out, q_out;
  logic [23:0]        loop_lim = 24'd1048576;
  logic [39:0]        lock_thr = 40'd2000;
  logic [7:0]         lock_need = 8'd3;
  logic [31:0]        tune_word;
  logic               locked;

  int  n_chk = 0, n_bad = 0;
  longint ncyc = 0;
  bit  done = 0;

  // bench model state
  logic [31:0] m_ph, m_tw, nom;
  longint m_integ, m_err, m_i, m_q;
  longint hist_i [8], hist_q [8];
  int  m_cnt, m_fill;
  bit  m_lock, m_ov, m_gd;

  always #2.5 clk = ~clk;

  chroma_qdemod dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .burst_gate(burst_gate), .out_ready(out_ready), .out_valid(out_valid),
    .i_out(i_out), .q_out(q_out), .loop_lim(loop_lim), .lock_thr(lock_thr),
    .lock_need(lock_need), .tune_word(tune_word), .locked(locked)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, ncyc);
    end
  endtask

  function automatic int bsin(input int a);
    real v;
    v = 2047.0 * $sin(2.0 * PI * (real'(a) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi($floor(v + 0.5)) : -$rtoi($floor(-v + 0.5));
  endfunction

  function automatic longint clampl(input longint v, input longint l);
    return (v > l) ? l : ((v < -l) ? -l : v);
  endfunction

  function automatic int tone(input real amp, input real f, input real phi);
    real v;
    int  r;
    v = amp * $cos(2.0 * PI * f * real'(ncyc) / FS + phi);
    r = (v >= 0.0) ? $rtoi($floor(v + 0.5)) : -$rtoi($floor(-v + 0.5));
    return (r > 511) ? 511 : ((r < -511) ? -511 : r);
  endfunction

  task automatic model_reset();
    m_ph = '0; m_tw = nom; m_integ = 0; m_err = 0; m_i = 0; m_q = 0;
    m_cnt = 0; m_fill = 0; m_lock = 0; m_ov = 0; m_gd = 0;
    for (int k = 0; k < 8; k++) begin hist_i[k] = 0; hist_q[k] = 0; end
  endtask

  task automatic do_reset(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk); rst = 1'b1; in_valid = 1'b0; burst_gate = 1'b0;
      @(posedge clk); #1; ncyc++;
    end
    @(negedge clk); rst = 1'b0;
    model_reset();
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 locked after reset", locked, 0);
    check("R1 tune_word after reset", tune_word, nom);
  endtask

  task automatic cycle(input bit vld, input int x, input bit gate, input bit ordy);
    bit acc, fall, stall;
    int s, c;
    longint pi_, pq_, si, sq, e, integ_n, off, mag;
    @(negedge clk);
    in_valid = vld; in_data = 10'(x); burst_gate = gate; out_ready = ordy;
    #1;
    check("R2 in_ready", in_ready, (!m_ov || ordy));
    acc   = vld && (!m_ov || ordy);
    stall = m_ov && !ordy;
    @(posedge clk); #1; ncyc++;
    if (acc) begin
      s = bsin(int'(m_ph[31:22]));
      c = bsin((int'(m_ph[31:22]) + 256) % 1024);
      pi_ = longint'(x) * c; pq_ = longint'(x) * s;
      for (int k = 7; k > 0; k--) begin hist_i[k] = hist_i[k-1]; hist_q[k] = hist_q[k-1]; end
      hist_i[0] = pi_; hist_q[0] = pq_;
      si = 0; sq = 0;
      for (int k = 0; k < 8; k++) begin si += hist_i[k]; sq += hist_q[k]; end
      m_i = si >>> 3; m_q = sq >>> 3;
      if (m_fill < 8) m_fill++;
      m_ov = (m_fill == 8);
      if (gate) m_err += pq_;
      m_ph = m_ph + m_tw;
    end else begin
      m_ov = m_ov && !ordy;
    end
    fall = m_gd && !gate;
    if (fall) begin
      e = m_err;
      integ_n = clampl(m_integ - (e >>> 12), longint'(loop_lim));
      off = clampl(integ_n - (e >>> 8), longint'(loop_lim));
      m_integ = integ_n;
      m_tw = nom + 32'(off);
      mag = (e < 0) ? -e : e;
      if (mag < longint'(lock_thr)) begin
        if (m_cnt < 255) m_cnt++;
        m_lock = (m_cnt >= int'(lock_need));
      end else begin
        m_cnt = 0; m_lock = 0;
      end
      m_err = 0;
      check("R9 offset within loop_lim", ((off <= longint'(loop_lim)) && (off >= -longint'(loop_lim))), 1);
    end
    m_gd = gate;
    check("R4 out_valid", out_valid, m_ov);
    if (m_ov) begin
      check(stall ? "R2 i_out held on stall" : "R3/R4 i_out", longint'(i_out), m_i);
      check(stall ? "R2 q_out held on stall" : "R3/R4 q_out", longint'(q_out), m_q);
    end
    check(fall ? "R5 R7 tune_word after fall" : "R6 tune_word held", tune_word, m_tw);
    check("R8 locked", locked, m_lock);
  endtask

  // one video line: burst at the nominal subcarrier, active chroma elsewhere
  task automatic run_line(input int glen, input int tot, input real amp_b, input real phi_b,
                          input real amp_a, input real f, input int vmod, input int rmod,
                          input bit stall_fall);
    bit g, v, r;
    int x;
    for (int t = 0; t < tot; t++) begin
      g = (t >= 5) && (t < 5 + glen);
      x = g ? tone(amp_b, FSC, phi_b) : tone(amp_a, f, 0.0);
      v = (vmod == 0) ? 1'b1 : ((t % vmod) != 0);
      r = (rmod == 0) ? 1'b1 : ((t % rmod) != 1);
      if (stall_fall && glen > 0 && t >= 3 + glen && t <= 6 + glen) r = 1'b0;
      cycle(v, x, g, r);
    end
  endtask

  initial begin
    nom = 32'($rtoi(FSC / FS * 4294967296.0 + 0.5));
    do_reset(3);
    // R3 R4: steady chroma, no burst, free flow
    run_line(0, 60, 0.0, 0.0, 300.0, FSC, 0, 0, 0);
    // R2: gaps on both sides of the stream
    run_line(0, 200, 0.0, 0.0, 250.0, FSC + 5.0e3, 3, 4, 0);
    // R8: three empty bursts give lock
    for (int k = 0; k < 3; k++) run_line(36, 100, 0.0, 0.0, 300.0, FSC, 0, 0, 0);
    check("R8 lock after three good bursts", locked, 1);
    // R8: a strong off-phase burst breaks lock
    run_line(36, 100, 400.0, 1.0, 300.0, FSC, 0, 0, 0);
    check("R8 lock cleared by bad burst", locked, 0);
    // R1: reset in the middle of operation
    do_reset(1);
    // R5 R7: tracking with an offset subcarrier and stream gaps
    for (int k = 0; k < 12; k++)
      run_line(40, 110, 300.0, 0.6, 200.0, FSC + 3.0e3, (k % 2) ? 4 : 0, (k % 3) ? 3 : 0, 0);
    // R9: tight bound, falls under output stall
    loop_lim = 24'd400;
    for (int k = 0; k < 4; k++) run_line(40, 110, 450.0, 1.4, 300.0, FSC, 0, 0, 1);
    check("R9 tune within bound", ((tune_word >= nom - 400) && (tune_word <= nom + 400)), 1);
    // R8: zero needed bursts and a threshold that always passes
    lock_need = 8'd0;
    lock_thr  = 40'hFF_FFFF_FFFF;
    run_line(36, 100, 450.0, 1.4, 300.0, FSC, 0, 0, 0);
    check("R8 lock with zero required bursts", locked, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule